// File: doc/BRIEF.md
# Two-bit saturating branch direction predictor

This block holds a direct-mapped array of 2-bit saturating counters that guess whether a conditional branch will be taken. The fetch stage presents the PC of the instruction being fetched on the lookup port. One clock later the block answers with a taken or not-taken guess for it. When the branch later resolves, the pipeline drives the resolved PC and the actual direction on the update port. The counter selected by that PC then moves one step toward the actual direction and stops at either end. Because of this, an entry that is firmly biased needs two wrong guesses in a row before its prediction changes.

The table has 2^IDX_W entries. It is selected by the PC bits just above the two byte-offset bits of a word-aligned instruction. There are no tags, so distinct branches that share index bits share a counter. After a reset the block walks through the whole table and sets every entry to weakly not-taken. It signals `init_done` when the walk is finished. Storage is written with one write port and synchronous reads, so it maps onto block RAM. One copy of the table serves fetch lookups and a second copy serves the read-modify-write of updates.

Top module: `bht_2bit`

## Requirements
- R1: While `rst` is high, `init_done` and `pred_taken` are 0. After reset is released, `init_done` rises on exactly the 2^IDX_W-th rising clock edge and stays high until the next reset. `pred_taken` is 0 for every lookup sampled before `init_done` is seen high.
- R2: Once initialisation is complete, every entry holds weakly not-taken (binary 01), regardless of any training done before the reset. The entry predicts not-taken, and a single taken update makes it predict taken.
- R3: The entry is selected by `PC[IDX_W+1:2]`, on both ports. PC bits 1:0 and every bit above IDX_W+1 do not affect which entry is read or written.
- R4: The counter encoding is 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken and 11 strongly taken. `pred_taken` is the upper counter bit, so it is 1 for states 10 and 11.
- R5: A taken update adds one to the counter and a not-taken update subtracts one. A taken update at 11 leaves 11, and a not-taken update at 00 leaves 00.
- R6: From a strong state, one update against its direction keeps the predicted direction. A second consecutive update against it flips the prediction.
- R7: The prediction for the PC on `lk_pc` during cycle t appears on `pred_taken` after the rising edge that ends cycle t, and it holds for one cycle.
- R8: An update presented in cycle t is seen by lookups presented in cycle t+2 and later. Lookups of the same entry presented in cycle t or t+1 return the value before the update.
- R9: Updates to the same entry on consecutive cycles all take effect, in order, with none lost.
- R10: When `up_valid` is 0, no entry changes, whatever `up_pc` and `up_taken` carry.
- R11: Updates presented before `init_done` is high are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the table initialisation walk |
| lk_pc | input | PC_W | PC of the instruction being fetched |
| pred_taken | output | 1 | Registered prediction for the PC presented one cycle earlier |
| init_done | output | 1 | High once every entry has been set to weakly not-taken |
| up_valid | input | 1 | A resolved branch is being reported this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual direction of the resolved branch |

## Verification
A lookup presented in cycle t is due on `pred_taken` after one rising edge. An update presented in cycle t shows up only in predictions for lookups presented two cycles later. `init_done` is due on the 2^IDX_W-th edge after reset is released. The bench drives inputs on the falling edge and compares outputs on the next falling edge. It runs a queue-free reference model that, at each rising edge, first forms the expected prediction and then applies the update held over from the previous edge. This reproduces the one- and two-cycle windows without looking inside the design. The directed checks add idle cycles after each update so that their expected values do not depend on those windows, apart from the cases that test the windows directly.

// File: rtl/bht_pkg.sv
package bht_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_WT  = 2'b10;
  localparam ctr_t CTR_ST  = 2'b11;

  // Saturating one-step move toward the resolved direction.
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == CTR_ST)  ? cur : ctr_t'(cur + 2'd1);
    else       nxt = (cur == CTR_SNT) ? cur : ctr_t'(cur - 2'd1);
    return nxt;
  endfunction

endpackage

// File: rtl/bht_sdp_ram.sv
// Simple dual-port storage: one write port, one registered read port,
// read-first on an address collision.
module bht_sdp_ram #(
  parameter int AW = 12,
  parameter int DW = 2
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/bht_init_seq.sv
// Walks every table address once after reset so the storage itself needs no reset.
module bht_init_seq #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  output logic          busy,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      ptr <= ptr + 1'b1;
      if (ptr == LAST) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/bht_upd_pipe.sv
// Two-stage read-modify-write for resolved branches with a one-deep bypass
// covering the write that the read-first storage has not yet returned.
module bht_upd_pipe
  import bht_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_v,
  input  logic [AW-1:0] in_idx,
  input  logic          in_tk,
  input  ctr_t          rd_cur,
  output logic          we,
  output logic [AW-1:0] widx,
  output ctr_t          wnew,
  output ctr_t          old_o,
  output logic          tk_o
);
  logic          s1_v;
  logic [AW-1:0] s1_idx;
  logic          s1_tk;
  logic          wl_v;
  logic [AW-1:0] wl_idx;
  ctr_t          wl_val;
  ctr_t          cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      wl_v <= 1'b0;
    end else begin
      s1_v <= in_v;
      wl_v <= s1_v;
    end
    s1_idx <= in_idx;
    s1_tk  <= in_tk;
    wl_idx <= s1_idx;
    wl_val <= wnew;
  end

  always_comb begin
    cur = (wl_v && (wl_idx == s1_idx)) ? wl_val : rd_cur;
  end

  assign wnew  = ctr_step(cur, s1_tk);
  assign we    = s1_v;
  assign widx  = s1_idx;
  assign old_o = cur;
  assign tk_o  = s1_tk;
endmodule

// File: rtl/bht_2bit.sv
module bht_2bit
  import bht_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  output logic            pred_taken,
  output logic            init_done,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);
  localparam int COPIES = 2;   // copy 0 serves fetch, copy 1 serves updates

  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] up_idx;
  logic             busy;
  logic [IDX_W-1:0] ptr;
  logic             upd_we;
  logic [IDX_W-1:0] upd_widx;
  ctr_t             upd_new;
  ctr_t             upd_old;
  logic             upd_tk;
  logic             wr_en;
  logic [IDX_W-1:0] wr_addr;
  ctr_t             wr_data;
  ctr_t             rd_q [COPIES];
  logic             ok_q;

  assign lk_idx = lk_pc[IDX_W+1:2];
  assign up_idx = up_pc[IDX_W+1:2];

  bht_init_seq #(.AW(IDX_W)) u_init (
    .clk  (clk),
    .rst  (rst),
    .busy (busy),
    .ptr  (ptr)
  );

  bht_upd_pipe #(.AW(IDX_W)) u_upd (
    .clk    (clk),
    .rst    (rst),
    .in_v   (up_valid & ~busy),
    .in_idx (up_idx),
    .in_tk  (up_taken),
    .rd_cur (rd_q[1]),
    .we     (upd_we),
    .widx   (upd_widx),
    .wnew   (upd_new),
    .old_o  (upd_old),
    .tk_o   (upd_tk)
  );

  always_comb begin
    wr_en   = busy | upd_we;
    wr_addr = busy ? ptr : upd_widx;
    wr_data = busy ? CTR_WNT : upd_new;
  end

  for (genvar g = 0; g < COPIES; g++) begin : g_copy
    bht_sdp_ram #(.AW(IDX_W), .DW(2)) u_ram (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr ((g == 0) ? lk_idx : up_idx),
      .rdata (rd_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) ok_q <= 1'b0;
    else     ok_q <= ~busy;
  end

  assign pred_taken = ok_q & rd_q[0][1];
  assign init_done  = ~busy;
endmodule

// File: rtl/bht_2bit_sva.sv
module bht_2bit_sva
  import bht_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic init_done,
  input logic pred_taken,
  input logic up_valid,
  input logic upd_we,
  input ctr_t upd_old,
  input ctr_t upd_new,
  input logic upd_tk
);
  p_reset_clears_done_r1: assert property (@(posedge clk) rst |=> !init_done);

  p_done_sticky_r1: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  p_no_pred_in_init_r1: assert property (@(posedge clk) disable iff (rst)
    !init_done |=> !pred_taken);

  p_ignore_update_in_init_r11: assert property (@(posedge clk) disable iff (rst)
    !init_done |=> !upd_we);

  p_no_write_without_valid_r10: assert property (@(posedge clk) disable iff (rst)
    !up_valid |=> !upd_we);

  p_sat_high_r5: assert property (@(posedge clk) disable iff (rst)
    (upd_we && upd_tk && upd_old == CTR_ST) |-> upd_new == CTR_ST);

  p_sat_low_r5: assert property (@(posedge clk) disable iff (rst)
    (upd_we && !upd_tk && upd_old == CTR_SNT) |-> upd_new == CTR_SNT);

  p_hyst_keep_dir_r6: assert property (@(posedge clk) disable iff (rst)
    (upd_we && (upd_old == CTR_ST || upd_old == CTR_SNT)) |-> upd_new[1] == upd_old[1]);
endmodule

bind bht_2bit bht_2bit_sva u_sva (
  .clk        (clk),
  .rst        (rst),
  .init_done  (init_done),
  .pred_taken (pred_taken),
  .up_valid   (up_valid),
  .upd_we     (upd_we),
  .upd_old    (upd_old),
  .upd_new    (upd_new),
  .upd_tk     (upd_tk)
);

// File: tb/bht_2bit_test.sv
module bht_2bit_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int PC_W  = 32;
  localparam int IDX_W = 6;
  localparam int N     = 1 << IDX_W;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PC_W-1:0] lk_pc = '0;
  logic            up_valid = 1'b0;
  logic [PC_W-1:0] up_pc = '0;
  logic            up_taken = 1'b0;
  logic            pred_taken;
  logic            init_done;

  int    total = 0;
  int    bad = 0;
  bit    finished = 0;
  bit    started = 0;
  string cur_req = "R1";

  // behavioural reference state
  int model [N];
  int edges = 0;
  bit pend_v = 0;
  int pend_idx = 0;
  bit pend_tk = 0;
  bit exp_pred = 0;
  bit exp_done = 0;
  bit ready = 0;

  always #2.5 clk = ~clk;

  bht_2bit #(.PC_W(PC_W), .IDX_W(IDX_W)) uut (
    .clk        (clk),
    .rst        (rst),
    .lk_pc      (lk_pc),
    .pred_taken (pred_taken),
    .init_done  (init_done),
    .up_valid   (up_valid),
    .up_pc      (up_pc),
    .up_taken   (up_taken)
  );

  function automatic int step_ctr(input int c, input bit tk);
    if (tk) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      edges    = 0;
      pend_v   = 0;
      exp_pred = 0;
      exp_done = 0;
      for (int i = 0; i < N; i++) model[i] = 1;
    end else begin
      ready    = (edges >= N);
      exp_pred = ready ? (model[int'(lk_pc[IDX_W+1:2])] >= 2) : 1'b0;
      if (pend_v) model[pend_idx] = step_ctr(model[pend_idx], pend_tk);
      pend_v   = ready && up_valid;
      pend_idx = int'(up_pc[IDX_W+1:2]);
      pend_tk  = up_taken;
      if (edges < N) edges++;
      exp_done = (edges >= N);
    end
  end

  task automatic chk(input bit act, input bit exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      chk(pred_taken, exp_pred, {cur_req, " model pred"});
      chk(init_done, exp_done, {cur_req, " model init_done"});
    end
  end

  // one cycle of stimulus with raw PCs; returns at the negedge after the consuming edge
  task automatic drive_pc(input logic [PC_W-1:0] lp, input bit uv,
                          input logic [PC_W-1:0] upc, input bit ut);
    lk_pc    = lp;
    up_valid = uv;
    up_pc    = upc;
    up_taken = ut;
    @(negedge clk);
  endtask

  task automatic drive(input int lk, input bit uv, input int ui, input bit ut);
    drive_pc(PC_W'(lk) << 2, uv, PC_W'(ui) << 2, ut);
  endtask

  task automatic upd(input int idx, input bit tk);
    drive(0, 1, idx, tk);
    drive(0, 0, 0, 0);
  endtask

  task automatic look(input int idx, input bit exp, input string what);
    drive(idx, 0, 0, 0);
    chk(pred_taken, exp, what);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    @(negedge clk);
    // R1: reset state
    cur_req = "R1";
    drive(0, 0, 0, 0);
    chk(init_done, 1'b0, "R1 done low in reset");
    chk(pred_taken, 1'b0, "R1 pred low in reset");
    rst = 1'b0;
    // R11: updates during the walk are discarded; count edges to init_done
    cur_req = "R11";
    cnt = 0;
    while (!init_done && cnt < 4 * N) begin
      drive(5, 1, 5, 1);
      cnt++;
    end
    chk(cnt == N, 1'b1, "R1 init_done after 2^IDX_W edges");
    drive(0, 0, 0, 0);
    drive(0, 0, 0, 0);
    look(5, 1'b0, "R11 update during init ignored");
    // R2 / R4: weakly not-taken start, one taken flips
    cur_req = "R2";
    look(17, 1'b0, "R2 entry starts not-taken");
    upd(17, 1);
    look(17, 1'b1, "R4 state 10 predicts taken");
    // R5 / R6 on entry 9
    cur_req = "R6";
    upd(9, 1); upd(9, 1); upd(9, 1);
    look(9, 1'b1, "R5 saturated high predicts taken");
    upd(9, 0);
    look(9, 1'b1, "R6 one miss from strong keeps taken");
    upd(9, 0);
    look(9, 1'b0, "R6 second miss flips");
    cur_req = "R5";
    upd(9, 0); upd(9, 0); upd(9, 0);
    upd(9, 1);
    look(9, 1'b0, "R5 saturated low then one taken stays not-taken");
    upd(9, 1);
    look(9, 1'b1, "R5 second taken predicts taken");
    // R3: index bits only
    cur_req = "R3";
    drive_pc('0, 1, (PC_W'(12) << 2) | (PC_W'(1) << 20) | PC_W'(3), 1);
    drive(0, 0, 0, 0);
    drive_pc((PC_W'(12) << 2) | PC_W'(2), 0, '0, 0);
    chk(pred_taken, 1'b1, "R3 alias through high and low bits");
    look(13, 1'b0, "R3 neighbour entry untouched");
    // R7 / R8: lookup windows around one update on entry 20
    cur_req = "R8";
    drive(20, 1, 20, 1);
    chk(pred_taken, 1'b0, "R8 same-cycle lookup sees old value");
    drive(20, 0, 0, 0);
    chk(pred_taken, 1'b0, "R8 next-cycle lookup sees old value");
    drive(20, 0, 0, 0);
    chk(pred_taken, 1'b1, "R7 R8 lookup two cycles later sees update");
    // R9: back-to-back updates
    cur_req = "R9";
    drive(0, 1, 30, 1);
    drive(0, 1, 30, 1);
    drive(0, 1, 30, 1);
    drive(0, 1, 30, 0);
    drive(0, 1, 30, 0);
    drive(0, 0, 0, 0);
    look(30, 1'b0, "R9 ST minus two gives weakly not-taken");
    drive(0, 1, 31, 1);
    drive(0, 1, 31, 1);
    drive(0, 1, 31, 0);
    drive(0, 0, 0, 0);
    look(31, 1'b1, "R9 two taken then one miss stays taken");
    // R10: valid low
    cur_req = "R10";
    for (int i = 0; i < 6; i++) drive(0, 0, 40, 1);
    look(40, 1'b0, "R10 no write when valid low");
    // loop-like streams, lookup and update each cycle
    cur_req = "R9 loop stream";
    for (int rep = 0; rep < 6; rep++) begin
      for (int b = 0; b < 4; b++) begin
        int trip;
        trip = (b == 0) ? 5 : (b == 1) ? 8 : (b == 2) ? 3 : 9;
        for (int it = 0; it < trip; it++) drive(44 + b, 1, 44 + b, it < trip - 1);
      end
    end
    drive(0, 0, 0, 0);
    drive(0, 0, 0, 0);
    // R2 again after a mid-run reset
    cur_req = "R2";
    rst = 1'b1;
    drive(0, 0, 0, 0);
    drive(0, 0, 0, 0);
    chk(init_done, 1'b0, "R1 done low after second reset");
    rst = 1'b0;
    cnt = 0;
    while (!init_done && cnt < 4 * N) begin
      drive(9, 0, 0, 0);
      cnt++;
    end
    chk(cnt == N, 1'b1, "R1 second walk length");
    drive(0, 0, 0, 0);
    look(9, 1'b0, "R2 trained entry back to weakly not-taken");
    upd(9, 1);
    look(9, 1'b1, "R2 single taken after reset predicts taken");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule